// File: doc/BRIEF.md
# Synchronous SRAM Data Path

This block is a single-port synchronous static memory. Its default depth is 1K words of 32 bits; setting `ADDR_W` to 15 gives the full 32K-word, 1-Mbit array. The address, the chip enables, the write controls and the write data are all captured on the rising clock edge. The shared data bus is split into three signals: an input word, an output word and a drive enable. A write stores either the selected byte lanes or the whole word. A write that has been captured is committed to the array on the next edge, so a read issued straight after it sees the new data.

A mode input selects the read path. In flow-through mode the array output goes straight to the bus. This gives a 2-1-1-1 burst: the data appears in the cycle after the address edge. In pipelined mode a rising-edge output register sits between the array and the bus. This gives a 3-1-1-1 burst: the data appears one edge later. A deselect or a write turns the bus off one stage sooner than a read brings data onto it. The output enable and the sleep input act on the drive without waiting for a clock. Sleep also blocks new commands and keeps the stored contents.

The port has no back-pressure. A command is taken on every edge at which the block is selected, and read data is presented at a fixed latency that the receiver cannot stall. Address sequencing is done by an external counter. In a system where the mode input would otherwise float, it is tied high to select pipelined mode.

Top module: `sram_dpath`

## Requirements
- R1: While reset is low and in the cycle after its release, `dq_oe` is 0 and `dq_out` is all zeros.
- R2: With `pipe_mode`=0, a read captured at edge N drives `dq_oe`=1 and the addressed word on `dq_out` between edge N and edge N+1.
- R3: With `pipe_mode`=1, a read captured at edge N drives its word between edge N+1 and edge N+2. Back-to-back reads therefore give one word per cycle. In the cycle after edge N the bus is not driven, unless a read was also captured at edge N-1.
- R4: A write with `bw`=1, `gw`=0 and a non-zero `bsel` changes only the byte lanes whose `bsel` bit is 1. Lane k is bits [8k+7:8k].
- R5: A write with `gw`=1 stores all four lanes, whatever the values of `bw` and `bsel`.
- R6: The block is selected only when `cs_a`, `cs_b` and `cs_c` are all 1. An edge with any of them at 0 is a deselect, and a write presented then leaves the array unchanged. In flow-through mode the bus stops driving right after the deselect edge. In pipelined mode the word of a read captured just before the deselect is still driven for one cycle, and the bus then stops.
- R7: In the cycle after a write is captured, `dq_oe` is 0 in both modes.
- R8: A read captured on the edge right after a write to the same address returns the newly written word, in both modes.
- R9: `dq_oe` follows `oe` without waiting for a clock edge, and `oe` has no effect on the stored data. `dq_out` reads all zeros whenever `dq_oe` is 0.
- R10: While `sleep` is 1, `dq_oe` is 0 without waiting for a clock edge and commands are not captured, so writes are ignored. The stored words are unchanged when `sleep` returns to 0.
- R11: An edge with `gw`=0 and either `bw`=0 or `bsel`=0 is a read when the block is selected.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| pipe_mode | input | 1 | 1 = pipelined read path, 0 = flow-through |
| cs_a | input | 1 | Chip enable A, active high |
| cs_b | input | 1 | Chip enable B, active high |
| cs_c | input | 1 | Chip enable C, active high |
| addr | input | ADDR_W | Word address |
| gw | input | 1 | Global write: store all lanes |
| bw | input | 1 | Byte-write enable, qualifies `bsel` |
| bsel | input | DATA_W/8 | Per-lane byte selects |
| dq_in | input | DATA_W | Write data from the shared bus |
| oe | input | 1 | Output enable, asynchronous |
| sleep | input | 1 | Low-power hold, asynchronous, active high |
| dq_out | output | DATA_W | Read data toward the shared bus |
| dq_oe | output | 1 | Drive enable for the shared bus |

## Verification
The bench builds the block with `ADDR_W`=4 and `DATA_W`=32. This gives 16 words and four byte lanes. At that size the bench can write and read back every address in both read modes, try every one of the 16 lane masks including the empty mask, and try all seven chip-enable combinations that leave the block deselected. Expected words are computed in the bench from an address-derived pattern, and the bench merges lane masks into them itself.

// File: rtl/sram_dpath_pkg.sv
package sram_dpath_pkg;

  localparam int LANE_W = 8;

  typedef enum logic [1:0] {
    OP_IDLE  = 2'd0,
    OP_READ  = 2'd1,
    OP_WRITE = 2'd2
  } op_e;

endpackage

// File: rtl/sram_cmd_stage.sv
module sram_cmd_stage
  import sram_dpath_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 32,
  localparam int LANES = DATA_W / LANE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sleep,
  input  logic              cs_a,
  input  logic              cs_b,
  input  logic              cs_c,
  input  logic [ADDR_W-1:0] addr,
  input  logic              gw,
  input  logic              bw,
  input  logic [LANES-1:0]  bsel,
  input  logic [DATA_W-1:0] wdata,
  output op_e               op_q,
  output logic [ADDR_W-1:0] addr_q,
  output logic [DATA_W-1:0] wdata_q,
  output logic [LANES-1:0]  mask_q
);

  logic             selected;
  logic [LANES-1:0] lane_mask;
  op_e              op_d;

  // selection requires every enable high and no sleep
  always_comb begin
    selected  = cs_a & cs_b & cs_c & ~sleep;
    lane_mask = '0;
    if (gw)      lane_mask = '1;
    else if (bw) lane_mask = bsel;
    if (!selected)       op_d = OP_IDLE;
    else if (|lane_mask) op_d = OP_WRITE;
    else                 op_d = OP_READ;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_q    <= OP_IDLE;
      addr_q  <= '0;
      wdata_q <= '0;
      mask_q  <= '0;
    end else begin
      op_q <= op_d;
      if (selected) begin
        addr_q  <= addr;
        wdata_q <= wdata;
        mask_q  <= lane_mask;
      end
    end
  end

endmodule

// File: rtl/sram_lane_array.sv
module sram_lane_array
  import sram_dpath_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 32,
  localparam int LANES = DATA_W / LANE_W,
  localparam int DEPTH = 1 << ADDR_W
) (
  input  logic              clk,
  input  logic              we,
  input  logic [LANES-1:0]  mask,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata
);

  // one storage column per byte lane
  for (genvar k = 0; k < LANES; k++) begin : g_lane
    logic [LANE_W-1:0] col [DEPTH];

    always_ff @(posedge clk) begin
      if (we && mask[k]) col[waddr] <= wdata[k*LANE_W +: LANE_W];
    end

    assign rdata[k*LANE_W +: LANE_W] = col[raddr];
  end

endmodule

// File: rtl/sram_read_path.sv
module sram_read_path
  import sram_dpath_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pipe_mode,
  input  logic              oe,
  input  logic              sleep,
  input  op_e               op_q,
  input  logic [DATA_W-1:0] rdata,
  output logic [DATA_W-1:0] dq_out,
  output logic              dq_oe
);

  logic              rd_stage;
  logic [DATA_W-1:0] out_reg;
  logic              drive_flow;
  logic              drive_pipe;
  logic              drive;
  logic [DATA_W-1:0] word_sel;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_stage <= 1'b0;
      out_reg  <= '0;
    end else begin
      rd_stage <= (op_q == OP_READ);
      if (op_q == OP_READ) out_reg <= rdata;
    end
  end

  // flow-through drives while the captured command is a read;
  // pipelined drives from the one-deep read stage, cut by a captured write
  always_comb begin
    drive_flow = (op_q == OP_READ);
    drive_pipe = rd_stage && (op_q != OP_WRITE);
    drive      = (pipe_mode ? drive_pipe : drive_flow) & oe & ~sleep;
    word_sel   = pipe_mode ? out_reg : rdata;
    dq_oe      = drive;
    dq_out     = drive ? word_sel : '0;
  end

endmodule

// File: rtl/sram_dpath.sv
module sram_dpath
  import sram_dpath_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 32,
  localparam int LANES = DATA_W / LANE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pipe_mode,
  input  logic              cs_a,
  input  logic              cs_b,
  input  logic              cs_c,
  input  logic [ADDR_W-1:0] addr,
  input  logic              gw,
  input  logic              bw,
  input  logic [LANES-1:0]  bsel,
  input  logic [DATA_W-1:0] dq_in,
  input  logic              oe,
  input  logic              sleep,
  output logic [DATA_W-1:0] dq_out,
  output logic              dq_oe
);

  op_e              op_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q;
  logic [LANES-1:0]  mask_q;
  logic [DATA_W-1:0] rdata;

  sram_cmd_stage #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_cmd (
    .clk     (clk),
    .rst_n   (rst_n),
    .sleep   (sleep),
    .cs_a    (cs_a),
    .cs_b    (cs_b),
    .cs_c    (cs_c),
    .addr    (addr),
    .gw      (gw),
    .bw      (bw),
    .bsel    (bsel),
    .wdata   (dq_in),
    .op_q    (op_q),
    .addr_q  (addr_q),
    .wdata_q (wdata_q),
    .mask_q  (mask_q)
  );

  // a captured write commits on the following edge
  sram_lane_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_array (
    .clk   (clk),
    .we    (op_q == OP_WRITE),
    .mask  (mask_q),
    .waddr (addr_q),
    .wdata (wdata_q),
    .raddr (addr_q),
    .rdata (rdata)
  );

  sram_read_path #(.DATA_W(DATA_W)) u_rd (
    .clk       (clk),
    .rst_n     (rst_n),
    .pipe_mode (pipe_mode),
    .oe        (oe),
    .sleep     (sleep),
    .op_q      (op_q),
    .rdata     (rdata),
    .dq_out    (dq_out),
    .dq_oe     (dq_oe)
  );

endmodule

// File: rtl/sram_dpath_chk.sv
module sram_dpath_chk #(
  parameter int LANES = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             pipe_mode,
  input logic             cs_a,
  input logic             cs_b,
  input logic             cs_c,
  input logic             gw,
  input logic             bw,
  input logic [LANES-1:0] bsel,
  input logic             oe,
  input logic             sleep,
  input logic             dq_oe
);

  logic acc, wr_cmd, rd_cmd;
  logic rd1, rd2, wr1;

  always_comb begin
    acc    = cs_a & cs_b & cs_c & ~sleep;
    wr_cmd = acc & (gw | (bw & (|bsel)));
    rd_cmd = acc & ~wr_cmd;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd1 <= 1'b0;
      rd2 <= 1'b0;
      wr1 <= 1'b0;
    end else begin
      rd1 <= rd_cmd;
      rd2 <= rd1;
      wr1 <= wr_cmd;
    end
  end

  p_reset_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> !dq_oe);

  p_flow_read_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!pipe_mode && rd1 && oe && !sleep) |-> dq_oe);

  p_pipe_read_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (pipe_mode && rd2 && !wr1 && oe && !sleep) |-> dq_oe);

  p_flow_desel_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!pipe_mode && !rd1) |-> !dq_oe);

  p_pipe_desel_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (pipe_mode && !rd2) |-> !dq_oe);

  p_write_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    wr1 |-> !dq_oe);

  p_oe_low_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !oe |-> !dq_oe);

  p_sleep_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    sleep |-> !dq_oe);

endmodule

bind sram_dpath sram_dpath_chk #(.LANES(LANES)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .pipe_mode (pipe_mode),
  .cs_a      (cs_a),
  .cs_b      (cs_b),
  .cs_c      (cs_c),
  .gw        (gw),
  .bw        (bw),
  .bsel      (bsel),
  .oe        (oe),
  .sleep     (sleep),
  .dq_oe     (dq_oe)
);

// File: tb/sim_sram_dpath.sv
`timescale 1ns/1ps
module sim_sram_dpath;

  localparam int AW = 4;
  localparam int NW = 1 << AW;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        pipe_mode = 1'b0;
  logic        cs_a = 1'b0, cs_b = 1'b0, cs_c = 1'b0;
  logic [AW-1:0] addr = '0;
  logic        gw = 1'b0, bw = 1'b0;
  logic [3:0]  bsel = '0;
  logic [31:0] dq_in = '0;
  logic        oe = 1'b1, sleep = 1'b0;
  logic [31:0] dq_out;
  logic        dq_oe;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  logic [31:0] model [NW];

  always #10 clk = ~clk;

  sram_dpath #(.ADDR_W(AW), .DATA_W(32)) u0 (
    .clk(clk), .rst_n(rst_n), .pipe_mode(pipe_mode),
    .cs_a(cs_a), .cs_b(cs_b), .cs_c(cs_c), .addr(addr),
    .gw(gw), .bw(bw), .bsel(bsel), .dq_in(dq_in),
    .oe(oe), .sleep(sleep), .dq_out(dq_out), .dq_oe(dq_oe)
  );

  function automatic logic [31:0] pat(input int a);
    return 32'h1357_9BDF ^ (32'(a) * 32'h0101_0101) ^ (32'(a) << 28);
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic cyc(input logic [2:0] cs, input int a, input logic g, input logic b,
                     input logic [3:0] s, input logic [31:0] d);
    {cs_c, cs_b, cs_a} = cs;
    addr = AW'(a); gw = g; bw = b; bsel = s; dq_in = d;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic rd(input int a);
    cyc(3'b111, a, 1'b0, 1'b0, 4'h0, 32'h0);
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    cyc(3'b111, a, 1'b1, 1'b0, 4'h0, d);
    model[a] = d;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 in reset oe", {31'b0, dq_oe}, 32'h0);
    chk("R1 in reset data", dq_out, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 after reset oe", {31'b0, dq_oe}, 32'h0);
    chk("R1 after reset data", dq_out, 32'h0);

    // R5: global write with bw/bsel varied per address
    for (int a = 0; a < NW; a++) begin
      cyc(3'b111, a, 1'b1, a[0], 4'(a), pat(a));
      model[a] = pat(a);
      chk("R7 no drive after write", {31'b0, dq_oe}, 32'h0);
    end
    // R2 flow-through readback
    for (int a = 0; a < NW; a++) begin
      rd(a);
      chk("R2 flow oe", {31'b0, dq_oe}, 32'h1);
      chk("R5 R2 flow data", dq_out, model[a]);
    end

    // R4/R11: every lane mask
    for (int m = 0; m < 16; m++) begin
      logic [31:0] d;
      d = ~pat(m) ^ 32'h5A5A_A5A5;
      cyc(3'b111, m, 1'b0, 1'b1, 4'(m), d);
      if (m == 0) begin
        chk("R11 empty mask reads oe", {31'b0, dq_oe}, 32'h1);
        chk("R11 empty mask reads data", dq_out, model[0]);
      end else begin
        chk("R7 byte write quiet", {31'b0, dq_oe}, 32'h0);
      end
      for (int k = 0; k < 4; k++)
        if (m[k]) model[m][k*8 +: 8] = d[k*8 +: 8];
    end
    for (int a = 0; a < NW; a++) begin
      rd(a);
      chk("R4 lane merge", dq_out, model[a]);
    end

    // R6: deselect combinations
    for (int c = 0; c < 7; c++) begin
      cyc(3'(c), 3, 1'b1, 1'b0, 4'h0, 32'hDEAD_0000 | 32'(c));
      chk("R6 flow deselect quiet", {31'b0, dq_oe}, 32'h0);
      rd(3);
      chk("R6 deselect write ignored", dq_out, model[3]);
    end

    // R8 flow
    wr(9, 32'hCAFE_0009);
    rd(9);
    chk("R8 flow read after write", dq_out, 32'hCAFE_0009);

    // R9 output enable
    oe = 1'b0;
    rd(2);
    chk("R9 oe low quiet", {31'b0, dq_oe}, 32'h0);
    chk("R9 oe low zero data", dq_out, 32'h0);
    oe = 1'b1;
    #1;
    chk("R9 oe async on", {31'b0, dq_oe}, 32'h1);
    chk("R9 oe data", dq_out, model[2]);

    // R10 sleep
    rd(4);
    sleep = 1'b1;
    #1;
    chk("R10 sleep async off", {31'b0, dq_oe}, 32'h0);
    cyc(3'b111, 4, 1'b1, 1'b0, 4'h0, 32'hBAD0_BAD0);
    chk("R10 sleep quiet", {31'b0, dq_oe}, 32'h0);
    sleep = 1'b0;
    rd(4);
    chk("R10 sleep retains", dq_out, model[4]);

    // pipelined mode
    wr(0, model[0]);
    pipe_mode = 1'b1;
    rd(0);
    chk("R3 pipe first cycle quiet", {31'b0, dq_oe}, 32'h0);
    for (int a = 1; a < NW; a++) begin
      rd(a);
      chk("R3 pipe oe", {31'b0, dq_oe}, 32'h1);
      chk("R3 pipe data", dq_out, model[a-1]);
    end
    cyc(3'b000, 0, 1'b0, 1'b0, 4'h0, 32'h0);
    chk("R6 pipe deselect keeps last oe", {31'b0, dq_oe}, 32'h1);
    chk("R6 pipe deselect keeps last data", dq_out, model[NW-1]);
    cyc(3'b000, 0, 1'b0, 1'b0, 4'h0, 32'h0);
    chk("R6 pipe deselect then off", {31'b0, dq_oe}, 32'h0);

    wr(11, 32'h0B0B_1111);
    rd(11);
    rd(12);
    chk("R8 pipe read after write", dq_out, 32'h0B0B_1111);
    rd(1);
    wr(13, 32'h1313_ABCD);
    chk("R7 pipe write quiet", {31'b0, dq_oe}, 32'h0);
    rd(13);
    rd(13);
    chk("R8 pipe readback", dq_out, 32'h1313_ABCD);

    finish_run();
  end

endmodule